// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block scans an eight-position multiplexed seven-segment display. It keeps one segment byte per digit position in a small pattern buffer. It enables exactly one digit at a time by pulling that digit's select line low, and it presents that digit's segment byte on the shared segment bus. It holds the digit for a dwell period, then moves to the next position. After the eighth position it wraps back to the first and keeps cycling.

The host loads patterns through a simple write port. A new byte appears the next time its digit comes up in the scan, so a slot that is already showing never changes partway through. The host also sets the dwell length, in clock cycles, on a 16-bit input. The scanner reads that input at the start of each slot and counts it down.

Top module: `seg_scan_mux`

## Requirements
- R1: While `rst_n` is low, `dig_sel_n` is 8'hFF (every digit off) and `seg_out` is 8'h00.
- R2: From the first rising clock edge after reset is released, exactly one bit of `dig_sel_n` is low at all times.
- R3: Successive slots drive `dig_sel_n` through 7F, BF, DF, EF, F7, FB, FD, FE (hex): the single zero rotates right by one bit per slot. After FE the sequence returns to 7F and repeats without end.
- R4: The slot whose select pattern has bit (7-k) low shows buffer entry k on `seg_out`. Entry 0 goes with 7F and entry 7 goes with FE. The select pattern and the segment byte change on the same clock edge.
- R5: Each slot lasts exactly `dwell` clock cycles. `dwell` is sampled on the edge that starts the slot, and the remaining time is counted down to the next step.
- R6: A `dwell` value of zero gives a slot one clock cycle long.
- R7: When `wr_en` is high at a rising edge, `wr_data` is stored into entry `wr_addr` (3 bits, 0 to 7). This applies in reset as well.
- R8: A write does not change `seg_out` during the slot that is currently showing. The new byte is shown the next time that entry's slot comes up.
- R9: The first slot after reset release shows entry 0 with pattern 7F, loaded on the first rising edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dwell | input | 16 | Slot length in clock cycles (0 is treated as 1) |
| wr_en | input | 1 | Pattern buffer write strobe |
| wr_addr | input | 3 | Buffer entry to write |
| wr_data | input | 8 | Segment byte to store |
| seg_out | output | 8 | Segment byte of the enabled digit |
| dig_sel_n | output | 8 | Active-low digit enables, one low at a time |

## Verification
The scan is run with eight distinct segment bytes in the buffer, so any mismatch between a select position and its buffer entry shows up as a wrong byte. Two full passes at a dwell of three cycles check the rotation order, the wrap from FE back to 7F, and the slot length. A second run with a dwell of zero checks the one-cycle minimum slot. A third run writes to the entry that is currently showing. The segment byte must stay unchanged for the rest of that slot and then show the new value one full pass later. This separates a buffer read taken at slot start from one that passes through live.

// File: rtl/seg_scan_mux.sv
module seg_scan_mux #(
  parameter int DIGITS = 8,
  parameter int SEG_W  = 8,
  parameter int CNT_W  = 16,
  localparam int AW    = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  dwell,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [SEG_W-1:0]  wr_data,
  output logic [SEG_W-1:0]  seg_out,
  output logic [DIGITS-1:0] dig_sel_n
);

  logic [SEG_W-1:0]  pat [DIGITS];
  logic [AW-1:0]     cur, nidx;
  logic [CNT_W-1:0]  cnt, len;
  logic              active, step;
  logic [DIGITS-1:0] top_bit;

  assign top_bit = {1'b1, {(DIGITS-1){1'b0}}};
  assign len  = (dwell == '0) ? CNT_W'(1) : dwell;
  assign step = !active || cnt == CNT_W'(1);
  assign nidx = (!active || cur == AW'(DIGITS-1)) ? '0 : AW'(cur + 1'b1);

  always_ff @(posedge clk)
    if (wr_en) pat[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cur       <= '0;
      cnt       <= '0;
      seg_out   <= '0;
      dig_sel_n <= '1;
    end else if (step) begin
      active    <= 1'b1;
      cur       <= nidx;
      cnt       <= len;
      seg_out   <= pat[nidx];
      dig_sel_n <= ~(top_bit >> nidx);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2
  one_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> $countones(~dig_sel_n) == 1);

  // R3
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && dig_sel_n != $past(dig_sel_n)) |->
      dig_sel_n == {$past(dig_sel_n[0]), $past(dig_sel_n[DIGITS-1:1])});

  // R8
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && $stable(dig_sel_n)) |-> $stable(seg_out));

  // R6
  dwell_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt != '0);

  // R9
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> dig_sel_n == ~top_bit);

endmodule

// File: tb/tb_seg_scan_mux.sv
module tb_seg_scan_mux;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] dwell = 16'd3;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  seg_out, dig_sel_n;
  int tests = 0, fails = 0;
  bit done = 0;

  // {segment byte, expected select}
  localparam logic [15:0] VEC [8] = '{
    16'h3F_7F, 16'h06_BF, 16'h5B_DF, 16'h4F_EF,
    16'h66_F7, 16'h6D_FB, 16'h7D_FD, 16'h07_FE};

  seg_scan_mux dut (.clk(clk), .rst_n(rst_n), .dwell(dwell), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .seg_out(seg_out), .dig_sel_n(dig_sel_n));

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [7:0] esel, logic [7:0] eseg);
    tests++;
    if (dig_sel_n !== esel || seg_out !== eseg) begin
      fails++;
      $display("FAIL %s: sel=%h seg=%h expected sel=%h seg=%h", req, dig_sel_n, seg_out, esel, eseg);
    end
  endtask

  task automatic restart(logic [15:0] d);
    @(negedge clk); rst_n = 0; dwell = d;
    @(negedge clk); chk("R1", 8'hFF, 8'h00);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); wr_en = 1; wr_addr = 3'(i); wr_data = VEC[i][15:8];
    end
    @(negedge clk); wr_en = 0;
    chk("R1", 8'hFF, 8'h00);

    // main scan: two passes, dwell 3 (R3 R4 R5 R7 R9)
    restart(16'd3);
    for (int k = 0; k < 16; k++)
      for (int c = 0; c < 3; c++) begin
        chk(k == 0 ? "R9" : (k == 8 ? "R3" : "R5"), VEC[k%8][7:0], VEC[k%8][15:8]);
        @(negedge clk);
      end

    // zero dwell gives one-cycle slots (R6)
    restart(16'd0);
    for (int k = 0; k < 10; k++) begin
      chk("R6", VEC[k%8][7:0], VEC[k%8][15:8]);
      @(negedge clk);
    end

    // write to showing entry (R8)
    restart(16'd4);
    chk("R4", 8'h7F, VEC[0][15:8]);
    wr_en = 1; wr_addr = 0; wr_data = 8'h5A;
    @(negedge clk); wr_en = 0;
    for (int c = 0; c < 3; c++) begin
      chk("R8", 8'h7F, VEC[0][15:8]);
      @(negedge clk);
    end
    for (int k = 1; k < 8; k++)
      for (int c = 0; c < 4; c++) begin
        chk("R4", VEC[k][7:0], VEC[k][15:8]);
        @(negedge clk);
      end
    chk("R8", 8'h7F, 8'h5A);
    @(negedge clk); rst_n = 0;
    @(negedge clk); chk("R1", 8'hFF, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule